// File: doc/BRIEF.md
# Paged Address Translation Unit with Translation Cache

This block turns logical addresses from a processor into physical addresses through a single-level page table held in memory. Each logical address is split into a page number (upper bits) and a byte offset (lower bits). The page number is first compared against every entry of a small fully associative translation cache. A hit answers on the next cycle and makes no memory access. On a miss, the block performs a table walk. It reads one table entry at the table base plus the page number, waits a fixed read latency, and then either answers with a translation and caches it, or reports a fault.

Page numbers at or beyond the table length input are refused before any lookup takes effect. Entries whose resident bit is clear produce a not-present fault. Translated writes keep the entry's modify bit set in memory. A write that finds a cached entry not yet known to be modified goes through a walk so that the write-back takes place. Only one request is in flight at a time: `busy` holds the processor off during a walk. The `flush` input empties the cache in one cycle. It is meant for use whenever the table base is changed.

Top module: `page_xlate_unit`

## Requirements
- R1: A successful translation returns `rsp_paddr` = {frame, offset}. The offset is the low OFS_W bits of `req_vaddr`, passed through unchanged.
- R2: A read that hits the cache raises `rsp_valid` on the cycle after acceptance, with no fault and no pulse on `pt_rd_en`.
- R3: On a miss, exactly one table read is issued, at address `tbl_base` + page number. The answer arrives RD_LAT+2 cycles after acceptance, and a repeat of the same page then hits.
- R4: A table entry is PTE_W = FR_W+2 bits wide. Bit 0 is the resident flag, bit 1 is the modify flag, and bits [FR_W+1:2] hold the frame number.
- R5: A page number greater than or equal to `tbl_len` answers on the next cycle with `rsp_fault`=1 and `rsp_range`=1, and makes no table read. This check takes priority over a cache hit.
- R6: An entry with the resident flag clear answers with `rsp_fault`=1 and `rsp_range`=0. It is not cached, so a repeat walks again.
- R7: Every translated write leaves the entry's modify flag set in memory. A write that misses, or hits a cached entry not marked modified, walks and writes the entry back with bit 1 set. A write that hits an entry marked modified answers in one cycle with no memory access.
- R8: The cache holds TLB_ENTRIES (default 8) entries. A fill goes to the entry already holding that page if there is one, else to the lowest free entry, else to a round-robin victim whose pointer starts at entry 0 and advances only when it is used.
- R9: A `flush` pulse invalidates every cache entry in one cycle, so the next access to any page walks.
- R10: `busy` is high from the cycle after a miss is accepted until the walk ends. Requests presented while `busy` is high are ignored.
- R11: While `rst_n` is low, `busy`, `rsp_valid`, `pt_rd_en` and `pt_wr_en` are low, and the cache comes out of reset empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when `busy` is low |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | VA_W | Logical address |
| busy | output | 1 | Table walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_range | output | 1 | Fault was a page number beyond the table length |
| rsp_paddr | output | PA_W | Physical address (valid when no fault) |
| tbl_base | input | AW | Page table start address in table memory |
| tbl_len | input | PN_W+1 | Number of pages in the table |
| flush | input | 1 | Invalidate every cache entry |
| pt_rd_en | output | 1 | Table memory read strobe |
| pt_wr_en | output | 1 | Table memory write strobe (modify write-back) |
| pt_addr | output | AW | Table memory address for read and write |
| pt_rd_data | input | PTE_W | Read data, valid RD_LAT cycles after the read strobe |
| pt_wr_data | output | PTE_W | Write-back data |

## Verification
The assertions assume that table memory returns data exactly RD_LAT cycles after the cycle in which `pt_rd_en` is high. They also assume that `flush`, `tbl_base` and `tbl_len` change only while no walk is running. The bench models the memory with that fixed delay and drives all-ones data at any other time, so a mistimed capture shows up. It changes the configuration inputs and pulses `flush` only between responses, when `busy` is low. It presents a request while `busy` is high only in the one directed test that checks that such requests are ignored.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  // Table entry field positions (the walker and the bench both decode these).
  localparam int PTE_RES_BIT   = 0;
  localparam int PTE_MOD_BIT   = 1;
  localparam int PTE_FRAME_LSB = 2;

  typedef enum logic [1:0] {
    OUT_NONE,
    OUT_XLATE,
    OUT_RANGE,
    OUT_ABSENT
  } out_kind_e;
endpackage

// File: rtl/pxu_tlb.sv
module pxu_tlb #(
  parameter int ENTRIES = 8,
  parameter int PN_W    = 8,
  parameter int FR_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PN_W-1:0] lk_page,
  output logic            lk_hit,
  output logic [FR_W-1:0] lk_frame,
  output logic            lk_dirty,
  input  logic            fill_en,
  input  logic [PN_W-1:0] fill_page,
  input  logic [FR_W-1:0] fill_frame,
  input  logic            fill_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_vld;
  logic [PN_W-1:0]    ent_tag   [ENTRIES];
  logic [FR_W-1:0]    ent_frame [ENTRIES];
  logic [ENTRIES-1:0] ent_dirty;
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_by_rr;

  // Associative compare, one comparator per entry.
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g]   = ent_vld[g] && (ent_tag[g] == lk_page);
      assign fill_match[g] = ent_vld[g] && (ent_tag[g] == fill_page);
    end
  endgenerate

  always_comb begin
    lk_frame = '0;
    lk_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_frame = lk_frame | ent_frame[i];
        lk_dirty = lk_dirty | ent_dirty[i];
      end
    end
  end
  assign lk_hit = |lk_match;

  // Fill slot: same page, else lowest free, else round-robin victim.
  always_comb begin
    logic found;
    found    = 1'b0;
    fill_idx = rr_ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && fill_match[i]) begin
        fill_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !ent_vld[i]) begin
        fill_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    fill_by_rr = !found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld   <= '0;
      ent_dirty <= '0;
      rr_ptr    <= '0;
    end else if (flush) begin
      ent_vld <= '0;
    end else if (fill_en) begin
      ent_vld[fill_idx]   <= 1'b1;
      ent_tag[fill_idx]   <= fill_page;
      ent_frame[fill_idx] <= fill_frame;
      ent_dirty[fill_idx] <= fill_dirty;
      if (fill_by_rr)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // R8: a page is never held by two entries
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R8: the round-robin victim is only taken when every entry is occupied
  a_r8_victim_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && fill_by_rr) |-> (&ent_vld));

  // R9: flush empties the cache on the next cycle
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_vld == '0));
endmodule

// File: rtl/pxu_walker.sv
module pxu_walker #(
  parameter int AW     = 16,
  parameter int PN_W   = 8,
  parameter int PTE_W  = 10,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  input  logic [PN_W-1:0]  page,
  input  logic             wb_en,
  input  logic [PTE_W-1:0] wb_data,
  output logic             busy,
  output logic             done,
  output logic [PTE_W-1:0] pte,
  output logic             pt_rd_en,
  output logic             pt_wr_en,
  output logic [AW-1:0]    pt_addr,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic [PTE_W-1:0] pt_wr_data
);
  localparam int CNT_W = $clog2(RD_LAT + 1);

  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] b,
                                               input logic [PN_W-1:0] p);
    return b + AW'(p);
  endfunction

  logic             active;
  logic [CNT_W-1:0] wait_cnt;
  logic             rd_q;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [PTE_W-1:0] wdat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wait_cnt <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= wb_en;
      if (wb_en) wdat_q <= wb_data;
      if (start && !active) begin
        active   <= 1'b1;
        wait_cnt <= '0;
        rd_q     <= 1'b1;
        addr_q   <= entry_addr(base, page);
      end else if (active) begin
        if (wait_cnt == CNT_W'(RD_LAT)) active <= 1'b0;
        else                            wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  assign busy       = active;
  assign done       = active && (wait_cnt == CNT_W'(RD_LAT));
  assign pte        = pt_rd_data;
  assign pt_rd_en   = rd_q;
  assign pt_wr_en   = wr_q;
  assign pt_addr    = addr_q;
  assign pt_wr_data = wdat_q;

  // R3: a walk starts with one read strobe in the following cycle
  a_r3_read_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> (pt_rd_en && busy));

  // R3: no second read is issued while waiting for data
  a_r3_one_read_per_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pt_rd_en) |=> !pt_rd_en);

  // R10: the walk ends right after the data cycle
  a_r10_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int VA_W        = 16,
  parameter int OFS_W       = 8,
  parameter int PA_W        = 16,
  parameter int AW          = 16,
  parameter int TLB_ENTRIES = 8,
  parameter int RD_LAT      = 2,
  localparam int PN_W       = VA_W - OFS_W,
  localparam int FR_W       = PA_W - OFS_W,
  localparam int PTE_W      = FR_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_range,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic [AW-1:0]    tbl_base,
  input  logic [PN_W:0]    tbl_len,
  input  logic             flush,
  output logic             pt_rd_en,
  output logic             pt_wr_en,
  output logic [AW-1:0]    pt_addr,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic [PTE_W-1:0] pt_wr_data
);
  import pxu_pkg::*;

  function automatic logic [PA_W-1:0] join_pa(input logic [FR_W-1:0] fr,
                                              input logic [OFS_W-1:0] ofs);
    return {fr, ofs};
  endfunction

  function automatic logic page_out_of_range(input logic [PN_W-1:0] pg,
                                             input logic [PN_W:0] len);
    return {1'b0, pg} >= len;
  endfunction

  logic [PN_W-1:0]  req_page;
  logic [OFS_W-1:0] req_ofs;
  assign req_page = req_vaddr[VA_W-1:OFS_W];
  assign req_ofs  = req_vaddr[OFS_W-1:0];

  // Cache and walker interconnect
  logic             lk_hit, lk_dirty;
  logic [FR_W-1:0]  lk_frame;
  logic             walk_busy, walk_done;
  logic [PTE_W-1:0] walk_pte;
  logic             fill_en, wb_en;
  logic [PTE_W-1:0] wb_data;

  // Held request for the walk
  logic [PN_W-1:0]  hold_page;
  logic [OFS_W-1:0] hold_ofs;
  logic             hold_write;

  // Named internal events
  logic ev_accept, ev_range_fault, ev_hit, ev_walk_start, ev_absent, ev_walk_ok;
  out_kind_e out_kind;

  assign ev_accept      = req_valid && !walk_busy;
  assign ev_range_fault = ev_accept && page_out_of_range(req_page, tbl_len);
  assign ev_hit         = ev_accept && !ev_range_fault && lk_hit
                          && (!req_write || lk_dirty);
  assign ev_walk_start  = ev_accept && !ev_range_fault && !ev_hit;
  assign ev_absent      = walk_done && !walk_pte[PTE_RES_BIT];
  assign ev_walk_ok     = walk_done &&  walk_pte[PTE_RES_BIT];

  assign fill_en = ev_walk_ok;
  assign wb_en   = ev_walk_ok && hold_write;
  assign wb_data = walk_pte | PTE_W'(1 << PTE_MOD_BIT);

  always_comb begin
    if (ev_range_fault)  out_kind = OUT_RANGE;
    else if (ev_hit)     out_kind = OUT_XLATE;
    else if (ev_absent)  out_kind = OUT_ABSENT;
    else if (ev_walk_ok) out_kind = OUT_XLATE;
    else                 out_kind = OUT_NONE;
  end

  pxu_tlb #(.ENTRIES(TLB_ENTRIES), .PN_W(PN_W), .FR_W(FR_W)) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_page    (req_page),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .lk_dirty   (lk_dirty),
    .fill_en    (fill_en),
    .fill_page  (hold_page),
    .fill_frame (walk_pte[PTE_FRAME_LSB +: FR_W]),
    .fill_dirty (walk_pte[PTE_MOD_BIT] | hold_write)
  );

  pxu_walker #(.AW(AW), .PN_W(PN_W), .PTE_W(PTE_W), .RD_LAT(RD_LAT)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_walk_start),
    .base       (tbl_base),
    .page       (req_page),
    .wb_en      (wb_en),
    .wb_data    (wb_data),
    .busy       (walk_busy),
    .done       (walk_done),
    .pte        (walk_pte),
    .pt_rd_en   (pt_rd_en),
    .pt_wr_en   (pt_wr_en),
    .pt_addr    (pt_addr),
    .pt_rd_data (pt_rd_data),
    .pt_wr_data (pt_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_page  <= '0;
      hold_ofs   <= '0;
      hold_write <= 1'b0;
    end else if (ev_walk_start) begin
      hold_page  <= req_page;
      hold_ofs   <= req_ofs;
      hold_write <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_range <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= (out_kind != OUT_NONE);
      rsp_fault <= (out_kind == OUT_RANGE) || (out_kind == OUT_ABSENT);
      rsp_range <= (out_kind == OUT_RANGE);
      if (ev_hit)
        rsp_paddr <= join_pa(lk_frame, req_ofs);
      else if (ev_walk_ok)
        rsp_paddr <= join_pa(walk_pte[PTE_FRAME_LSB +: FR_W], hold_ofs);
    end
  end

  assign busy = walk_busy;

  // R2: a hit answers next cycle without touching table memory
  a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (rsp_valid && !rsp_fault && !pt_rd_en));

  // R1: the offset of a hit passes through unchanged
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

  // R5: an out-of-range page faults next cycle with no read
  a_r5_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_fault |=> (rsp_valid && rsp_fault && rsp_range && !pt_rd_en));

  // R6: a non-resident entry faults and is neither written back nor cached
  a_r6_absent_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_absent |=> (rsp_valid && rsp_fault && !rsp_range && !pt_wr_en));

  // R7: every write-back carries the modify flag
  a_r7_wb_modify: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wr_en |-> pt_wr_data[PTE_MOD_BIT]);

  // R10: no response while a walk is outstanding
  a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);
endmodule

// File: tb/test_page_xlate_unit.sv
module test_page_xlate_unit;
  localparam int RD_LAT = 2;
  localparam int MISS   = RD_LAT + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        busy, rsp_valid, rsp_fault, rsp_range;
  logic [15:0] rsp_paddr;
  logic [15:0] tbl_base = 16'h0100;
  logic [8:0]  tbl_len  = 9'd16;
  logic        flush = 1'b0;
  logic        pt_rd_en, pt_wr_en;
  logic [15:0] pt_addr;
  logic [9:0]  pt_rd_data, pt_wr_data;

  always #2.5 clk = ~clk;

  page_xlate_unit #(.RD_LAT(RD_LAT)) i_page_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_range(rsp_range), .rsp_paddr(rsp_paddr),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .flush(flush),
    .pt_rd_en(pt_rd_en), .pt_wr_en(pt_wr_en), .pt_addr(pt_addr),
    .pt_rd_data(pt_rd_data), .pt_wr_data(pt_wr_data));

  // Table memory model: entry {frame, modify, resident}, fixed read delay.
  logic [9:0] mem [0:511];
  int rd_count = 0;
  int since = 0;
  always @(posedge clk) begin
    if (pt_rd_en) begin rd_count <= rd_count + 1; since <= 1; end
    else if (since != 0 && since < 100) since <= since + 1;
    if (pt_wr_en) mem[pt_addr[8:0]] <= pt_wr_data;
  end
  assign pt_rd_data = (since == RD_LAT) ? mem[pt_addr[8:0]] : 10'h3FF;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xlate(input logic wr, input logic [15:0] va, output logic f,
                       output logic r, output logic [15:0] pa, output int lat,
                       output int rd);
    int r0;
    @(negedge clk);
    while (busy) @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    f = rsp_fault; r = rsp_range; pa = rsp_paddr;
    rd = rd_count - r0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  typedef struct packed {
    logic       wr;
    logic [15:0] va;
    logic       flt;
    logic       rng;
    logic [15:0] pa;
    logic [7:0] rd;
    logic [7:0] lat;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 16'h0312, 1'b0, 1'b0, 16'h4312, 8'd1, 8'(MISS)}, // R3 miss
    '{1'b0, 16'h03AB, 1'b0, 1'b0, 16'h43AB, 8'd0, 8'd1},     // R2 hit
    '{1'b0, 16'h0500, 1'b1, 1'b0, 16'h0000, 8'd1, 8'(MISS)}, // R6 absent
    '{1'b0, 16'h1000, 1'b1, 1'b1, 16'h0000, 8'd0, 8'd1},     // R5 first bad page
    '{1'b0, 16'h0F01, 1'b0, 1'b0, 16'h4F01, 8'd1, 8'(MISS)}, // R1 last good page
    '{1'b1, 16'h0310, 1'b0, 1'b0, 16'h4310, 8'd1, 8'(MISS)}, // R7 clean-hit write
    '{1'b1, 16'h0311, 1'b0, 1'b0, 16'h4311, 8'd0, 8'd1},     // R7 dirty hit
    '{1'b0, 16'h0F02, 1'b0, 1'b0, 16'h4F02, 8'd0, 8'd1},     // R2 hit
    '{1'b0, 16'h0500, 1'b1, 1'b0, 16'h0000, 8'd1, 8'(MISS)}, // R6 not cached
    '{1'b0, 16'hFF00, 1'b1, 1'b1, 16'h0000, 8'd0, 8'd1},     // R5 far page
    '{1'b1, 16'h0E05, 1'b0, 1'b0, 16'h4E05, 8'd1, 8'(MISS)}  // R7 write miss
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic f, r;
    logic [15:0] pa;
    int lat, rd, r0;
    for (int p = 0; p < 512; p++) mem[p] = 10'h000;
    for (int p = 0; p < 16; p++) mem[256 + p] = {8'(8'h40 + p), 1'b0, 1'b1};
    mem[256 + 5] = {8'h45, 1'b0, 1'b0};  // R4 resident bit 0 clear

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !rsp_valid && !pt_rd_en && !pt_wr_en, "R11 reset outputs",
        {busy, rsp_valid, pt_rd_en, pt_wr_en}, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      xlate(VEC[i].wr, VEC[i].va, f, r, pa, lat, rd);
      chk(f == VEC[i].flt && r == VEC[i].rng, $sformatf("vec%0d fault kind", i),
          {f, r}, {VEC[i].flt, VEC[i].rng});
      if (!VEC[i].flt)
        chk(pa == VEC[i].pa, $sformatf("R1 R4 vec%0d paddr", i), pa, VEC[i].pa);
      chk(rd == int'(VEC[i].rd), $sformatf("R2 R3 vec%0d table reads", i), rd, VEC[i].rd);
      chk(lat == int'(VEC[i].lat), $sformatf("R3 vec%0d latency", i), lat, VEC[i].lat);
    end

    // R7 modify flags in memory
    @(negedge clk);
    chk(mem[256 + 3] == 10'h10F, "R7 page3 written back", mem[256 + 3], 10'h10F);
    chk(mem[256 + 14] == 10'h13B, "R7 page14 written back", mem[256 + 14], 10'h13B);
    chk(mem[256 + 15][1] == 1'b0, "R7 read leaves modify clear", mem[256 + 15], 10'h13D);

    // R5 length check beats a cached hit
    tbl_len = 9'd3;
    xlate(1'b0, 16'h0320, f, r, pa, lat, rd);
    chk(f && r && rd == 0, "R5 priority over hit", {f, r, 8'(rd)}, 10'h300);
    tbl_len = 9'd16;

    // R9 flush forces a walk
    do_flush();
    xlate(1'b0, 16'h0377, f, r, pa, lat, rd);
    chk(rd == 1 && pa == 16'h4377, "R9 walk after flush", {16'(rd), pa}, {16'd1, 16'h4377});

    // R8 replacement: pages 6..13 fill, 14 and 15 evict 6 and 7
    do_flush();
    for (int p = 6; p < 16; p++) xlate(1'b0, {8'(p), 8'h00}, f, r, pa, lat, rd);
    xlate(1'b0, 16'h0811, f, r, pa, lat, rd);
    chk(rd == 0 && pa == 16'h4811, "R8 survivor hits", {16'(rd), pa}, {16'd0, 16'h4811});
    xlate(1'b0, 16'h0622, f, r, pa, lat, rd);
    chk(rd == 1 && pa == 16'h4622, "R8 oldest evicted", {16'(rd), pa}, {16'd1, 16'h4622});

    // R10 requests during a walk are ignored
    do_flush();
    @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 16'h0A22;
    @(negedge clk);
    chk(busy, "R10 busy after miss accepted", busy, 1);
    req_vaddr = 16'h0C33;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 3;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    chk(rsp_paddr == 16'h4A22 && lat == MISS, "R10 original answered",
        {16'(lat), rsp_paddr}, {16'(MISS), 16'h4A22});
    repeat (4) begin
      @(negedge clk);
      chk(!rsp_valid && !busy, "R10 ignored request left no trace", {rsp_valid, busy}, 0);
    end
    chk(rd_count - r0 == 1, "R10 single read", rd_count - r0, 1);

    // R11 reset mid-walk clears busy and empties cache
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'h0B00;
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rsp_valid, "R11 reset during walk", {busy, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (RD_LAT + 2) @(negedge clk);
    xlate(1'b0, 16'h0A01, f, r, pa, lat, rd);
    chk(rd == 1, "R11 cache empty after reset", rd, 1);

    finish_run();
  end
endmodule